// File: doc/BRIEF.md
# Power-On Strap Latch Controller

This block manages a pin that serves two purposes in turn. When power becomes good, the pin's output driver stays off for a fixed number of reference-clock cycles. During that time an external pull resistor sets the pin level, and the block reads that level as a configuration strap. When the window closes, the block captures the synchronized pin level into a persistent bit. In the same cycle it turns on the pin driver, which then forwards a reference clock.

The captured bit chooses the frequency of a companion clock output. A strap to ground gives 48 MHz and a strap to supply gives 24 MHz. Downstream logic should ignore the strap until the block raises its done flag. The only way to clear the bit is to drop power-good, which models a full power cycle. Enabling the driver may cut the first forwarded clock pulse short, and that is accepted. The window length is a parameter in reference-clock cycles. The default is 28636 cycles, about 2 ms at a 14.318 MHz reference.

Top module: `strap_latch_ctrl`

## Requirements
- R1: While `pwr_good` is low, `pad_oe`, `pad_out`, `strap_done`, `strap_bit` and `sel_48m` are all 0, and the low level takes effect without waiting for a clock edge.
- R2: After `pwr_good` rises, `pad_oe` and `strap_done` stay 0 through the first WIN_CYCLES-1 rising edges of `ref_clk`, and `pad_out` stays 0 whatever `fwd_clk_in` does.
- R3: `strap_done` and `pad_oe` both go to 1 on the WIN_CYCLES-th rising edge of `ref_clk` after `pwr_good` rises.
- R4: The captured `strap_bit` equals the level `pad_in` had at rising edge WIN_CYCLES-2, because the pin passes through a two-flop synchronizer. A change on `pad_in` after that edge is not captured.
- R5: After capture, `sel_48m` is 1 when `strap_bit` is 0 (pin strapped to ground, 48 MHz) and 0 when `strap_bit` is 1 (pin strapped to supply, 24 MHz). Before capture, `sel_48m` is 0.
- R6: While `pad_oe` is 1, `pad_out` follows `fwd_clk_in` combinationally. Shortened first pulses are allowed.
- R7: After capture, and while `pwr_good` stays high, changes on `pad_in` have no effect on `strap_bit`, `strap_done`, `sel_48m` or `pad_oe`.
- R8: `strap_bit` reads 0 until `strap_done` is 1.
- R9: When `pwr_good` drops and rises again, the block starts a new window and samples the pin again, so the new strap value replaces the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock that times the window |
| pwr_good | input | 1 | Supply-good indication; low acts as asynchronous reset |
| pad_in | input | 1 | Level read back from the dual-function pin |
| fwd_clk_in | input | 1 | Clock forwarded to the pin once the driver is enabled |
| pad_oe | output | 1 | Pin driver enable; 0 means three-stated |
| pad_out | output | 1 | Data driven onto the pin (gated forwarded clock) |
| strap_bit | output | 1 | Captured strap value; 1 = strapped to supply |
| strap_done | output | 1 | Capture complete; strap outputs are valid |
| sel_48m | output | 1 | Companion clock select; 1 = 48 MHz, 0 = 24 MHz |

## Verification
The bench releases `pwr_good` at a falling edge and counts the rising edges that follow. At each falling edge it expects the driver off and the done flag low up to edge WIN_CYCLES-1, then expects both set after edge WIN_CYCLES. The synchronizer delay is checked by moving the pin one edge before and one edge after edge WIN_CYCLES-2, which must and must not reach the captured bit. Reset and pin-gating results have no register delay, so they are checked 1 ns after the bench changes `pwr_good` or `fwd_clk_in`.

// File: rtl/strap_latch_pkg.sv
package strap_latch_pkg;

    typedef enum logic [0:0] {
        ST_SAMPLE = 1'b0,
        ST_DRIVE  = 1'b1
    } strap_state_e;

    typedef struct packed {
        strap_state_e state;
        logic         strap;
        logic         done;
        logic         oe;
    } ctrl_regs_t;

    localparam ctrl_regs_t CTRL_RESET = '{state: ST_SAMPLE, strap: 1'b0, done: 1'b0, oe: 1'b0};

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d;
    logic [LAST:0] chain_q;

    always_comb begin
        chain_d[0] = async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_comb begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[LAST];
endmodule

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
    parameter int WIN_CYCLES = 28636
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(WIN_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;
    logic          hit;

    always_comb begin
        hit   = (cnt_q == LAST);
        cnt_d = cnt_q;
        if (run && !hit) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = run && hit;
endmodule

// File: rtl/strap_capture_ctrl.sv
module strap_capture_ctrl
    import strap_latch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_lvl,
    input  logic expire,
    output logic run,
    output logic oe,
    output logic strap,
    output logic done
);
    ctrl_regs_t r_d;
    ctrl_regs_t r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_SAMPLE: begin
                if (expire) begin
                    r_d.state = ST_DRIVE;
                    r_d.strap = sync_lvl;
                    r_d.done  = 1'b1;
                    r_d.oe    = 1'b1;
                end
            end
            ST_DRIVE: begin
                r_d = r_q;
            end
            default: r_d = CTRL_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= CTRL_RESET;
        else        r_q <= r_d;
    end

    assign run   = (r_q.state == ST_SAMPLE);
    assign oe    = r_q.oe;
    assign strap = r_q.strap;
    assign done  = r_q.done;
endmodule

// File: rtl/strap_latch_ctrl.sv
module strap_latch_ctrl #(
    parameter int WIN_CYCLES  = 28636,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic pwr_good,
    input  logic pad_in,
    input  logic fwd_clk_in,
    output logic pad_oe,
    output logic pad_out,
    output logic strap_bit,
    output logic strap_done,
    output logic sel_48m
);
    logic pad_sync;
    logic timer_run;
    logic timer_expire;
    logic oe_q;
    logic strap_q;
    logic done_q;

    strap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (ref_clk),
        .rst_n    (pwr_good),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    strap_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
        .clk    (ref_clk),
        .rst_n  (pwr_good),
        .run    (timer_run),
        .expire (timer_expire)
    );

    strap_capture_ctrl u_ctrl (
        .clk      (ref_clk),
        .rst_n    (pwr_good),
        .sync_lvl (pad_sync),
        .expire   (timer_expire),
        .run      (timer_run),
        .oe       (oe_q),
        .strap    (strap_q),
        .done     (done_q)
    );

    // Gating may clip the first forwarded pulse; that is accepted.
    assign pad_oe     = oe_q;
    assign pad_out    = fwd_clk_in & oe_q;
    assign strap_bit  = strap_q;
    assign strap_done = done_q;
    assign sel_48m    = done_q & ~strap_q;
endmodule

// File: rtl/strap_latch_checker.sv
module strap_latch_checker #(
    parameter int WIN_CYCLES = 28636
) (
    input logic ref_clk,
    input logic pwr_good,
    input logic pad_oe,
    input logic pad_out,
    input logic strap_bit,
    input logic strap_done,
    input logic sel_48m
);
    localparam int CW = $clog2(WIN_CYCLES + 1);
    localparam logic [CW-1:0] WLIM = CW'(WIN_CYCLES);

    logic [CW-1:0] edges_q;

    always_ff @(posedge ref_clk or negedge pwr_good) begin
        if (!pwr_good)          edges_q <= '0;
        else if (edges_q != WLIM) edges_q <= edges_q + 1'b1;
    end

    AST_QUIET_IN_WINDOW: assert property (@(posedge ref_clk) disable iff (!pwr_good)
        (edges_q != WLIM) |-> (!strap_done && !pad_oe && !pad_out)); // R2
    AST_DONE_AT_WINDOW_END: assert property (@(posedge ref_clk) disable iff (!pwr_good)
        (edges_q == WLIM) |-> (strap_done && pad_oe)); // R3
    AST_SEL_POLARITY: assert property (@(posedge ref_clk) disable iff (!pwr_good)
        strap_done |-> (sel_48m == !strap_bit)); // R5
    AST_STRAP_HELD: assert property (@(posedge ref_clk) disable iff (!pwr_good)
        strap_done |=> (strap_done && $stable(strap_bit))); // R7
    AST_STRAP_ZERO_EARLY: assert property (@(posedge ref_clk) disable iff (!pwr_good)
        !strap_done |-> (!strap_bit && !sel_48m)); // R8
endmodule

bind strap_latch_ctrl strap_latch_checker #(.WIN_CYCLES(WIN_CYCLES)) u_strap_chk (
    .ref_clk    (ref_clk),
    .pwr_good   (pwr_good),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .strap_bit  (strap_bit),
    .strap_done (strap_done),
    .sel_48m    (sel_48m)
);

// File: tb/strap_latch_ctrl_bench.sv
module strap_latch_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 40;

    logic ref_clk = 1'b0;
    logic pwr_good = 1'b0;
    logic pad_in = 1'b0;
    logic fwd_clk_in = 1'b0;
    logic pad_oe, pad_out, strap_bit, strap_done, sel_48m;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    strap_latch_ctrl #(.WIN_CYCLES(WIN)) u_strap_latch_ctrl (
        .ref_clk    (ref_clk),
        .pwr_good   (pwr_good),
        .pad_in     (pad_in),
        .fwd_clk_in (fwd_clk_in),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out),
        .strap_bit  (strap_bit),
        .strap_done (strap_done),
        .sel_48m    (sel_48m)
    );

    always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic power_down();
        @(negedge ref_clk);
        pwr_good = 1'b0;
        #1;
    endtask

    // Release power-good at a falling edge and wait for n rising edges.
    task automatic release_and_wait(input int n);
        @(negedge ref_clk);
        pwr_good = 1'b1;
        for (int k = 0; k < n; k++) @(negedge ref_clk);
    endtask

    task automatic t_reset_state();
        power_down();
        fwd_clk_in = 1'b1;
        #1;
        check("R1", "pad_oe",     pad_oe,     1'b0);
        check("R1", "pad_out",    pad_out,    1'b0);
        check("R1", "strap_done", strap_done, 1'b0);
        check("R1", "strap_bit",  strap_bit,  1'b0);
        check("R1", "sel_48m",    sel_48m,    1'b0);
        fwd_clk_in = 1'b0;
    endtask

    task automatic t_window(input logic val);
        power_down();
        pad_in = val;
        @(negedge ref_clk);
        pwr_good = 1'b1;
        for (int k = 1; k <= WIN; k++) begin
            @(negedge ref_clk);
            fwd_clk_in = 1'b1;
            #1;
            if (k < WIN) begin
                check("R2", "pad_oe in window",  pad_oe,     1'b0);
                check("R2", "pad_out in window", pad_out,    1'b0);
                check("R2", "done in window",    strap_done, 1'b0);
                check("R8", "strap before done", strap_bit,  1'b0);
            end else begin
                check("R3", "done at end",   strap_done, 1'b1);
                check("R3", "pad_oe at end", pad_oe,     1'b1);
                check("R4", "captured bit",  strap_bit,  val);
                check("R5", "sel_48m",       sel_48m,    ~val);
                check("R6", "pad_out high",  pad_out,    1'b1);
            end
            fwd_clk_in = 1'b0;
            #1;
            if (k == WIN) check("R6", "pad_out low", pad_out, 1'b0);
        end
    endtask

    task automatic t_persist(input logic val);
        for (int k = 0; k < 12; k++) begin
            @(negedge ref_clk);
            pad_in = ~pad_in;
            @(negedge ref_clk);
            check("R7", "strap held", strap_bit,  val);
            check("R7", "done held",  strap_done, 1'b1);
            check("R7", "oe held",    pad_oe,     1'b1);
            check("R7", "sel held",   sel_48m,    ~val);
        end
    endtask

    // Pin moves from 0 to 1 after `edges` rising edges of the window.
    task automatic t_late_change(input int edges, input logic exp);
        power_down();
        pad_in = 1'b0;
        release_and_wait(edges);
        pad_in = 1'b1;
        for (int k = edges; k < WIN; k++) @(negedge ref_clk);
        check("R4", "done after late change", strap_done, 1'b1);
        check("R4", "sync boundary capture",  strap_bit,  exp);
    endtask

    task automatic t_power_cycle();
        t_window(1'b1);
        power_down();
        check("R9", "done cleared",  strap_done, 1'b0);
        check("R9", "strap cleared", strap_bit,  1'b0);
        t_window(1'b0);
        check("R9", "new strap value", strap_bit, 1'b0);
        check("R9", "new select",      sel_48m,   1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_window(1'b0);
        t_persist(1'b0);
        t_window(1'b1);
        t_persist(1'b1);
        t_late_change(WIN - 3, 1'b1);
        t_late_change(WIN - 2, 1'b0);
        t_power_cycle();
        t_reset_state();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule